// File: doc/BRIEF.md
# Two-Wire Line Conditioner and Event Detector

This block sits between the raw clock and data pins of a two-wire serial slave and the protocol logic behind it. A fast system clock samples both lines. Each line passes through a two-flop synchroniser and then a digital spike filter. The filter accepts a new level only once the synchronised input has held that level for a programmable number of cycles. From the two filtered levels the block reports bus events as single-cycle pulses: a start, a stop, a sampled data bit on each clock rising edge, and each clock falling edge. It also keeps a busy flag for the current transaction.

The protocol logic asks for the data line to be pulled low through a request input. The block owns the open-drain output enable. A new request reaches the enable only after a fixed hold delay has run out following a filtered clock falling edge. The enable then follows the request until the clock rises again, so the slave can never create a false start or stop. The filter length and the hold delay are given in nanoseconds and converted to cycles from the system clock period.

Top module: `line_conditioner`

## Requirements
- R1: A level change on either line that lasts fewer than FILT_CYCLES system clocks (7 at defaults, for 50 ns at 8 ns) is suppressed. A change that lasts FILT_CYCLES clocks or longer is accepted.
- R2: A filtered data fall while the filtered clock is high and was high in the previous cycle produces a one-cycle startPulse and sets busBusy. This also applies while busBusy is already set (repeated start).
- R3: While busBusy is set, a filtered data rise while the filtered clock stays high produces a one-cycle stopPulse and clears busBusy.
- R4: While busBusy is set, each filtered clock rising edge produces a one-cycle bitValid, with bitValue equal to the filtered data level.
- R5: While busBusy is set, each filtered clock falling edge produces a one-cycle sclFall pulse.
- R6: While busBusy is clear, no stopPulse, bitValid or sclFall is reported. Only a start is recognised.
- R7: A data change while the clock is high never produces bitValid.
- R8: sdaOe does not change while the filtered clock is high. After a filtered clock fall it does not change for at least HOLD_CYCLES clocks (38 at defaults, for 300 ns).
- R9: Once the hold delay after a clock fall has expired and the clock is still low, sdaOe follows sdaPull (1 = pull the line low) with one cycle of latency.
- R10: Out of reset, busBusy, sdaOe and all event outputs are 0, and both filtered lines read high (bus idle).
- R11: startPulse and stopPulse are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw serial clock pin level |
| sdaIn | input | 1 | Raw serial data pin level |
| sdaPull | input | 1 | Request to pull data low (1) or release it (0) |
| startPulse | output | 1 | One-cycle start event |
| stopPulse | output | 1 | One-cycle stop event |
| bitValid | output | 1 | One-cycle strobe for a sampled data bit |
| bitValue | output | 1 | Data level sampled with bitValid |
| sclFall | output | 1 | One-cycle clock falling edge event |
| busBusy | output | 1 | High between a start and a stop |
| sdaOe | output | 1 | Open-drain enable for the data pin (1 = drive low) |

## Verification
The bench sends glitches on each line one cycle shorter than the filter length and exactly at the filter length. A filter off by one would let the short spike through as a false start or clock edge, or would drop the boundary pulse. It makes stop-shaped and clock-shaped activity on an idle bus, where a design that ignores the busy state would report stops, bits or clock falls. It checks the output enable in every cycle of the hold window after a clock fall, and again after a request is changed while the clock is high. An enable that moves too early, or that moves while the clock is high, would create a spurious start or stop on the wire. It also shifts in a mixed byte, so that a wrong sample edge or a data change mistaken for data shows up as a wrong value.

// File: rtl/line_cond_pkg.sv
package line_cond_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic holdArm;     // filtered clock just fell: start hold timer
    logic holdCancel;  // filtered clock just rose: close the drive window
  } dpStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/line_cond_dp.sv
module line_cond_dp
  import line_cond_pkg::*;
#(
  parameter int FILT = 7,
  parameter int HOLD = 38
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      sdaPull,
  input  dpStrobe_t strobe,
  output logic      sclFilt,
  output logic      sdaFilt,
  output logic      sdaOe
);
  localparam int CW = $clog2(FILT + 1);
  localparam int HW = $clog2(HOLD + 1);

  logic [1:0] rawIn;
  logic [1:0] filtLvl;
  assign rawIn = {sdaIn, sclIn};

  // one synchroniser plus spike filter per line
  for (genvar i = 0; i < 2; i++) begin : g_line
    logic syncA, syncB, lvl;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA <= 1'b1;
        syncB <= 1'b1;
        lvl   <= 1'b1;
        cnt   <= '0;
      end else begin
        syncA <= rawIn[i];
        syncB <= syncA;
        if (syncB == lvl) begin
          cnt <= '0;
        end else if (cnt == CW'(FILT - 1)) begin
          lvl <= syncB;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign filtLvl[i] = lvl;
  end

  assign sclFilt = filtLvl[0];
  assign sdaFilt = filtLvl[1];

  // hold timer and output enable
  logic [HW-1:0] holdCnt;
  logic holdActive, lowWindow, oeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt    <= '0;
      holdActive <= 1'b0;
      lowWindow  <= 1'b0;
      oeQ        <= 1'b0;
    end else begin
      if (strobe.holdCancel) begin
        holdActive <= 1'b0;
        lowWindow  <= 1'b0;
      end else if (strobe.holdArm) begin
        holdActive <= 1'b1;
        holdCnt    <= '0;
        lowWindow  <= 1'b0;
      end else if (holdActive) begin
        if (holdCnt == HW'(HOLD - 1)) begin
          holdActive <= 1'b0;
          lowWindow  <= 1'b1;
        end else begin
          holdCnt <= holdCnt + 1'b1;
        end
      end
      if (lowWindow && !filtLvl[0]) oeQ <= sdaPull;
    end
  end

  assign sdaOe = oeQ;
endmodule

// File: rtl/line_cond_ctl.sv
module line_cond_ctl
  import line_cond_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclFilt,
  input  logic      sdaFilt,
  output logic      startPulse,
  output logic      stopPulse,
  output logic      bitValid,
  output logic      bitValue,
  output logic      sclFall,
  output logic      busBusy,
  output dpStrobe_t strobe
);
  logic sclPrev, sdaPrev, busyQ;
  logic sclRise, sclFell, sclHeld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      busyQ   <= 1'b0;
    end else begin
      sclPrev <= sclFilt;
      sdaPrev <= sdaFilt;
      if (startPulse)     busyQ <= 1'b1;
      else if (stopPulse) busyQ <= 1'b0;
    end
  end

  assign sclRise = sclFilt & ~sclPrev;
  assign sclFell = ~sclFilt & sclPrev;
  assign sclHeld = sclFilt & sclPrev;

  assign startPulse = sclHeld & sdaPrev & ~sdaFilt;
  assign stopPulse  = sclHeld & ~sdaPrev & sdaFilt & busyQ;
  assign bitValid   = sclRise & busyQ;
  assign bitValue   = sdaFilt;
  assign sclFall    = sclFell & busyQ;
  assign busBusy    = busyQ;

  assign strobe.holdArm    = sclFell;
  assign strobe.holdCancel = sclRise;
endmodule

// File: rtl/line_conditioner.sv
module line_conditioner
  import line_cond_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int SPIKE_NS      = 50,
  parameter int HOLD_NS       = 300
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic sdaPull,
  output logic startPulse,
  output logic stopPulse,
  output logic bitValid,
  output logic bitValue,
  output logic sclFall,
  output logic busBusy,
  output logic sdaOe
);
  localparam int FILT_CYCLES = ceilDiv(SPIKE_NS, CLK_PERIOD_NS);
  localparam int HOLD_CYCLES = ceilDiv(HOLD_NS, CLK_PERIOD_NS);

  dpStrobe_t strobe;
  logic sclFilt, sdaFilt;

  line_cond_dp #(.FILT(FILT_CYCLES), .HOLD(HOLD_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaPull(sdaPull),
    .strobe(strobe), .sclFilt(sclFilt), .sdaFilt(sdaFilt), .sdaOe(sdaOe)
  );

  line_cond_ctl u_ctl (
    .clk(clk), .rstN(rstN), .sclFilt(sclFilt), .sdaFilt(sdaFilt),
    .startPulse(startPulse), .stopPulse(stopPulse), .bitValid(bitValid),
    .bitValue(bitValue), .sclFall(sclFall), .busBusy(busBusy), .strobe(strobe)
  );
endmodule

// File: rtl/line_cond_sva.sv
module line_cond_sva #(
  parameter int HOLD = 38
) (
  input logic clk,
  input logic rstN,
  input logic sclFilt,
  input logic startPulse,
  input logic stopPulse,
  input logic bitValid,
  input logic sclFall,
  input logic busBusy,
  input logic sdaOe
);
  localparam int SW = $clog2(HOLD + 2);
  logic [SW-1:0] sinceFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          sinceFall <= '0;
    else if (sclFilt)                   sinceFall <= '0;
    else if (sinceFall != SW'(HOLD + 1)) sinceFall <= sinceFall + 1'b1;
  end

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(startPulse && stopPulse));
  p_start_once_r11: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);
  p_busy_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> busBusy);
  p_busy_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |=> !busBusy);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busBusy |-> (!bitValid && !sclFall && !stopPulse));
  p_bit_on_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (sclFilt && !$past(sclFilt)));
  p_oe_frozen_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sclFilt && $past(sclFilt)) |-> $stable(sdaOe));
  p_oe_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!sclFilt && sinceFall >= SW'(1) && sinceFall <= SW'(HOLD)) |-> $stable(sdaOe));
endmodule

bind line_conditioner line_cond_sva #(.HOLD(HOLD_CYCLES)) u_sva (
  .clk(clk), .rstN(rstN), .sclFilt(sclFilt), .startPulse(startPulse),
  .stopPulse(stopPulse), .bitValid(bitValid), .sclFall(sclFall),
  .busBusy(busBusy), .sdaOe(sdaOe)
);

// File: tb/line_conditioner_bench.sv
module line_conditioner_bench;
  localparam int FILT = 7;
  localparam int HOLD = 38;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1, sdaIn = 1'b1, sdaPull = 1'b0;
  logic startPulse, stopPulse, bitValid, bitValue, sclFall, busBusy, sdaOe;

  int nRun = 0, nFail = 0;
  int nStart = 0, nStop = 0, nBit = 0, nFall = 0;
  logic [7:0] shiftIn = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  line_conditioner u_line_conditioner (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaPull(sdaPull),
    .startPulse(startPulse), .stopPulse(stopPulse), .bitValid(bitValid),
    .bitValue(bitValue), .sclFall(sclFall), .busBusy(busBusy), .sdaOe(sdaOe)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (startPulse) nStart++;
      if (stopPulse)  nStop++;
      if (sclFall)    nFall++;
      if (bitValid) begin
        nBit++;
        shiftIn = {shiftIn[6:0], bitValue};
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    sclIn = 1'b0; waitCyc(HALF);
    sdaIn = b;    waitCyc(HALF);
    sclIn = 1'b1; waitCyc(HALF);
  endtask

  task automatic testReset();
    chk("R10 busBusy", busBusy, 0);
    chk("R10 sdaOe", sdaOe, 0);
    chk("R10 events", startPulse + stopPulse + bitValid + sclFall, 0);
  endtask

  task automatic testIdle();
    int s0 = nStop, b0 = nBit, f0 = nFall;
    sclIn = 1'b0; waitCyc(HALF);
    sdaIn = 1'b0; waitCyc(HALF);
    sclIn = 1'b1; waitCyc(HALF);
    sdaIn = 1'b1; waitCyc(HALF);
    sclIn = 1'b0; waitCyc(HALF);
    sclIn = 1'b1; waitCyc(HALF);
    chk("R6 no stop when idle", nStop - s0, 0);
    chk("R6 no bit when idle", nBit - b0, 0);
    chk("R6 no fall when idle", nFall - f0, 0);
    chk("R6 still idle", busBusy, 0);
  endtask

  task automatic testStart();
    int s0 = nStart, b0 = nBit;
    sdaIn = 1'b0; waitCyc(HALF);
    chk("R2 start count", nStart - s0, 1);
    chk("R2 busy set", busBusy, 1);
    chk("R7 no bit on data change", nBit - b0, 0);
  endtask

  task automatic testByte(input logic [7:0] val);
    int b0 = nBit, f0 = nFall;
    for (int i = 7; i >= 0; i--) sendBit(val[i]);
    chk("R4 bit count", nBit - b0, 8);
    chk("R4 byte value", shiftIn, val);
    chk("R5 fall count", nFall - f0, 8);
  endtask

  task automatic testSpikes();
    int s0 = nStart, p0 = nStop, b0 = nBit, f0 = nFall;
    // lines high, bus busy
    sdaIn = 1'b0; waitCyc(FILT - 1); sdaIn = 1'b1; waitCyc(HALF);
    chk("R1 short data spike start", nStart - s0, 0);
    chk("R1 short data spike stop", nStop - p0, 0);
    sclIn = 1'b0; waitCyc(FILT - 1); sclIn = 1'b1; waitCyc(HALF);
    chk("R1 short clock spike fall", nFall - f0, 0);
    chk("R1 short clock spike bit", nBit - b0, 0);
    chk("R1 still busy", busBusy, 1);
    sdaIn = 1'b0; waitCyc(FILT); sdaIn = 1'b1; waitCyc(HALF);
    chk("R1 boundary pulse start", nStart - s0, 1);
    chk("R3 boundary pulse stop", nStop - p0, 1);
    chk("R3 busy cleared", busBusy, 0);
  endtask

  task automatic testHold();
    int early = 0;
    sdaPull = 1'b1; waitCyc(HALF);
    chk("R8 no drive with clock high", sdaOe, 0);
    sclIn = 1'b0;
    for (int i = 0; i < HOLD; i++) begin
      @(negedge clk);
      if (sdaOe) early++;
    end
    chk("R8 hold window", early, 0);
    waitCyc(FILT + 12);
    chk("R9 drive after hold", sdaOe, 1);
    sdaPull = 1'b0; waitCyc(3);
    chk("R9 follow release", sdaOe, 0);
    sclIn = 1'b1; waitCyc(HALF);
    sdaPull = 1'b1; waitCyc(30);
    chk("R8 frozen with clock high", sdaOe, 0);
    sdaPull = 1'b0;
  endtask

  task automatic testStop();
    int p0, b0;
    sclIn = 1'b0; waitCyc(HALF);
    sdaIn = 1'b0; waitCyc(HALF);
    sclIn = 1'b1; waitCyc(HALF);
    p0 = nStop; b0 = nBit;
    sdaIn = 1'b1; waitCyc(HALF);
    chk("R3 stop count", nStop - p0, 1);
    chk("R3 busy clear", busBusy, 0);
    chk("R7 no bit on stop", nBit - b0, 0);
  endtask

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(3);
    testReset();
    testIdle();
    testStart();
    testByte(8'hA5);
    testSpikes();
    testStart();
    testByte(8'h3C);
    testHold();
    testStop();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule